// File: doc/BRIEF.md
# Streaming Mirror-Padding Front End

This block sits ahead of an FIR filter and pads each finite frame of signed samples at both ends with reflected copies of the samples nearest that end. The filter then sees data at the frame borders that has no artificial step. A frame arrives as a valid/start/last stream. The same frame leaves as a valid/first/last stream that is exactly `N + 2E` samples long. `N` is the frame length and `E` is the padding depth on each side, set by a parameter.

Interior samples pass through a short delay line unchanged. Two small last-in-first-out stores collect the samples at the head and at the tail of the frame and replay them in reverse. A per-cycle source select picks the delay line or a store output. Two mode pins, sampled at frame start, choose the reflection point and the sign of the padding. In half-sample reflection the edge sample is repeated. In whole-sample reflection the mirror sits on the edge sample, which is not repeated. The anti-symmetric variant negates every padding sample through a saturating two's-complement stage. `in_ready` drops while the block replays padding or flushes its delay line.

Top module: `sym_border_ext`

## Requirements
- R1: With `mode_whole`=0 (half-sample), the output frame begins with x[E-1], …, x[1], x[0] and is followed by x[0], x[1], ….
- R2: With `mode_whole`=1 (whole-sample), the output frame begins with x[E], …, x[1] and is followed by x[0], x[1], ….
- R3: The right padding mirrors about x[N-1]. Half-sample mode gives x[N-1], x[N-2], …, x[N-E]. Whole-sample mode gives x[N-2], …, x[N-1-E].
- R4: With `mode_anti`=1, every padding sample is emitted negated. Interior samples are never negated.
- R5: Negating the most negative value (MSB 1, all other bits 0) gives the most positive value.
- R6: Each output frame holds exactly N+2E valid samples. `out_first` marks only the first of them and `out_last` marks only the final one.
- R7: `mode_whole` and `mode_anti` are taken from the cycle that accepts the start sample. Changes during the rest of the frame have no effect.
- R8: `in_ready` is low from the cycle after the sample with `in_last` is accepted until the last padding sample has been issued. From that point on, output samples come out back to back.
- R9: Interior samples leave in their arrival order with their values unchanged, whatever idle cycles separate the input samples.
- R10: During reset, `out_valid` is low and `in_ready` is high.
- R11: While no frame is open, a valid sample without `in_start` is discarded and never appears in any output.
- R12: Frames must satisfy N ≥ E+1. A frame of exactly E+1 samples is padded correctly in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample |
| in_start | input | 1 | Input sample is x[0] of a frame |
| in_last | input | 1 | Input sample is x[N-1] of a frame |
| in_data | input | W | Signed input sample |
| mode_whole | input | 1 | 1 = whole-sample reflection, 0 = half-sample |
| mode_anti | input | 1 | 1 = negate padding samples |
| out_valid | output | 1 | Output sample present |
| out_first | output | 1 | First sample of the padded frame |
| out_last | output | 1 | Final sample of the padded frame |
| out_data | output | W | Signed output sample |

## Verification
The shortest legal frame (E+1 samples) puts the final input inside the head-collection phase. A design that only looks for `in_last` in the streaming phase would hang or run the frame into the next one. Frames built of the extreme values, in anti-symmetric mode, catch a negator that wraps the most negative value back onto itself. They also catch a sign flip that leaks onto interior samples. Mode pins toggled after the start sample show whether the reflection is taken from live pins, which would give a wrong offset of one sample at the tail. Random idle gaps and junk samples sent between frames expose a delay line that shifts on idle cycles, and a block that admits unframed data.

// File: rtl/sym_ext_pkg.sv
package sym_ext_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL,
      ST_LEFT,
      ST_STREAM,
      ST_DRAIN,
      ST_RIGHT
   } ext_state_e;

endpackage

// File: rtl/sym_ext_negate.sv
module sym_ext_negate #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   logic [W-1:0] flipped;
   assign flipped = (~din) + {{(W-1){1'b0}}, 1'b1};

   generate
      if (SATURATE) begin : g_sat
         assign dout = (din == MOST_NEG) ? MOST_POS : flipped;
      end else begin : g_wrap
         assign dout = flipped;
      end
   endgenerate
endmodule

// File: rtl/sym_ext_delay.sv
module sym_ext_delay #(
   parameter int W     = 16,
   parameter int DEPTH = 5
) (
   input  logic         clk,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] oldest
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("sym_ext_delay: DEPTH must be at least 1");
      end
      for (genvar k = 0; k < DEPTH; k++) begin : g_stage
         logic [W-1:0] q;
         if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (en) q <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (en) q <= g_stage[k-1].q;
            end
         end
      end
   endgenerate

   assign oldest = g_stage[DEPTH-1].q;
endmodule

// File: rtl/sym_ext_lifo.sv
module sym_ext_lifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] top
);
   localparam int PW = $clog2(DEPTH + 1);

   logic [PW-1:0]             ptr_q;
   logic [DEPTH-1:0][W-1:0]   masked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (push && !pop) begin
         ptr_q <= ptr_q + PW'(1);
      end else if (pop && !push && ptr_q != '0) begin
         ptr_q <= ptr_q - PW'(1);
      end
   end

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("sym_ext_lifo: DEPTH must be at least 1");
      end
      for (genvar k = 0; k < DEPTH; k++) begin : g_ent
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (push && !pop && ptr_q == PW'(k)) q <= din;
         end
         assign masked[k] = (ptr_q == PW'(k + 1)) ? q : '0;
      end
   endgenerate

   always_comb begin
      top = '0;
      for (int k = 0; k < DEPTH; k++) top = top | masked[k];
   end
endmodule

// File: rtl/sym_border_ext.sv
module sym_border_ext #(
   parameter int W       = 16,
   parameter int E       = 4,
   parameter bit SAT_NEG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic         in_start,
   input  logic         in_last,
   input  logic [W-1:0] in_data,
   input  logic         mode_whole,
   input  logic         mode_anti,
   output logic         out_valid,
   output logic         out_first,
   output logic         out_last,
   output logic [W-1:0] out_data
);
   import sym_ext_pkg::*;

   localparam int              DLY      = E + 1;
   localparam int              CW       = $clog2(E + 2);
   localparam logic [CW-1:0]   IDX_EDGE = CW'(E);
   localparam logic [CW-1:0]   IDX_POP  = CW'(E - 1);

   generate
      if (W < 2) begin : g_bad_w
         $error("sym_border_ext: W must be at least 2");
      end
      if (E < 1) begin : g_bad_e
         $error("sym_border_ext: E must be at least 1");
      end
   endgenerate

   ext_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          whole_q, anti_q, end_seen_q;

   logic          accept, take_start, shift_en;
   logic          push_l, pop_l, push_r, pop_r;
   logic [W-1:0]  tap_old, top_l, top_r, neg_src, neg_out, mirror_val;
   logic          emit, emit_first, emit_last;
   logic [W-1:0]  emit_data;

   assign in_ready   = (state_q == ST_IDLE) || (state_q == ST_FILL) || (state_q == ST_STREAM);
   assign accept     = in_valid && in_ready;
   assign take_start = accept && (state_q == ST_IDLE) && in_start;

   assign shift_en = take_start
                   || (accept && (state_q == ST_FILL || state_q == ST_STREAM))
                   || (state_q == ST_DRAIN);

   assign push_l = (take_start && !mode_whole)
                 || (accept && state_q == ST_FILL && (whole_q || cnt_q != IDX_EDGE));
   assign pop_l  = (state_q == ST_LEFT);
   assign push_r = (state_q == ST_DRAIN) && (whole_q ? (cnt_q != IDX_EDGE) : (cnt_q != '0));
   assign pop_r  = (state_q == ST_RIGHT);

   sym_ext_delay #(.W(W), .DEPTH(DLY)) u_delay (
      .clk    (clk),
      .en     (shift_en),
      .din    (in_data),
      .oldest (tap_old)
   );

   sym_ext_lifo #(.W(W), .DEPTH(E)) u_lifo_head (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_l),
      .pop   (pop_l),
      .din   (in_data),
      .top   (top_l)
   );

   sym_ext_lifo #(.W(W), .DEPTH(E)) u_lifo_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_r),
      .pop   (pop_r),
      .din   (tap_old),
      .top   (top_r)
   );

   assign neg_src = (state_q == ST_LEFT) ? top_l : top_r;

   sym_ext_negate #(.W(W), .SATURATE(SAT_NEG)) u_neg (
      .din  (neg_src),
      .dout (neg_out)
   );

   assign mirror_val = anti_q ? neg_out : neg_src;

   always_comb begin
      emit       = 1'b0;
      emit_first = 1'b0;
      emit_last  = 1'b0;
      emit_data  = tap_old;
      unique case (state_q)
         ST_LEFT: begin
            emit       = 1'b1;
            emit_first = (cnt_q == '0);
            emit_data  = mirror_val;
         end
         ST_STREAM: emit = accept;
         ST_DRAIN:  emit = 1'b1;
         ST_RIGHT: begin
            emit      = 1'b1;
            emit_last = (cnt_q == IDX_POP);
            emit_data = mirror_val;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         whole_q    <= 1'b0;
         anti_q     <= 1'b0;
         end_seen_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (take_start) begin
                  whole_q    <= mode_whole;
                  anti_q     <= mode_anti;
                  end_seen_q <= 1'b0;
                  cnt_q      <= CW'(1);
                  state_q    <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (accept) begin
                  if (cnt_q == IDX_EDGE) begin
                     end_seen_q <= in_last;
                     cnt_q      <= '0;
                     state_q    <= ST_LEFT;
                  end else begin
                     cnt_q <= cnt_q + CW'(1);
                  end
               end
            end
            ST_LEFT: begin
               if (cnt_q == IDX_POP) begin
                  cnt_q   <= '0;
                  state_q <= end_seen_q ? ST_DRAIN : ST_STREAM;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            ST_STREAM: begin
               if (accept && in_last) begin
                  cnt_q   <= '0;
                  state_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (cnt_q == IDX_EDGE) begin
                  cnt_q   <= '0;
                  state_q <= ST_RIGHT;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            ST_RIGHT: begin
               if (cnt_q == IDX_POP) begin
                  cnt_q   <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= emit;
         out_first <= emit_first;
         out_last  <= emit_last;
         if (emit) out_data <= emit_data;
      end
   end
endmodule

// File: rtl/sym_border_ext_chk.sv
module sym_border_ext_chk #(
   parameter int E = 4
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic in_start,
   input logic in_last,
   input logic out_valid,
   input logic out_first,
   input logic out_last
);
   logic        open_q, tail_q;
   logic [15:0] n_in_q, out_idx_q;
   logic        acc;

   assign acc = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q    <= 1'b0;
         tail_q    <= 1'b0;
         n_in_q    <= '0;
         out_idx_q <= '0;
      end else begin
         if (acc && !open_q && in_start) begin
            open_q <= !in_last;
            n_in_q <= 16'd1;
         end else if (acc && open_q) begin
            n_in_q <= n_in_q + 16'd1;
            if (in_last) open_q <= 1'b0;
         end
         if (acc && in_last && (open_q || in_start)) tail_q <= 1'b1;
         else if (out_valid && out_last) tail_q <= 1'b0;
         if (out_valid) out_idx_q <= out_first ? 16'd1 : out_idx_q + 16'd1;
      end
   end

   // R6: frame markers only on valid samples
   p_mark_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_first || out_last) |-> out_valid);

   // R6: a padded frame never starts and ends on one sample
   p_mark_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_first && out_last));

   // R6: output length equals input length plus both paddings
   p_frame_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (out_idx_q + 16'd1 == n_in_q + 16'(2 * E)));

   // R8: input closed right after the last sample is taken
   p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_last && (open_q || in_start)) |=> !in_ready);

   // R8: tail of the frame comes out without bubbles
   p_tail_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_q && out_valid && !out_last) |=> out_valid);
endmodule

bind sym_border_ext sym_border_ext_chk #(.E(E)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_start  (in_start),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_first (out_first),
   .out_last  (out_last)
);

// File: tb/sym_border_ext_bench.sv
module sym_border_ext_bench;
   localparam int W    = 16;
   localparam int E    = 4;
   localparam int NMAX = 40;
   localparam int OMAX = NMAX + 2 * E + 8;
   localparam logic signed [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};
   localparam logic signed [W-1:0] VMAX = {1'b0, {(W-1){1'b1}}};

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic         rst_n;
   logic         in_valid, in_ready, in_start, in_last;
   logic [W-1:0] in_data;
   logic         mode_whole, mode_anti;
   logic         out_valid, out_first, out_last;
   logic [W-1:0] out_data;

   sym_border_ext #(.W(W), .E(E)) u_sym_border_ext (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_start   (in_start),
      .in_last    (in_last),
      .in_data    (in_data),
      .mode_whole (mode_whole),
      .mode_anti  (mode_anti),
      .out_valid  (out_valid),
      .out_first  (out_first),
      .out_last   (out_last),
      .out_data   (out_data)
   );

   int n_chk = 0;
   int n_fail = 0;

   logic signed [W-1:0] x [NMAX];
   logic signed [W-1:0] got [OMAX];
   int  gcnt, first_cnt, last_cnt, first_pos, last_pos;
   bit  done, tail, ready_bad;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
      end
   endtask

   function automatic logic signed [W-1:0] neg_sat(input logic signed [W-1:0] v);
      return (v == VMIN) ? VMAX : -v;
   endfunction

   function automatic logic signed [W-1:0] rand_val();
      int r = $urandom % 8;
      if (r == 0) return VMIN;
      if (r == 1) return VMAX;
      return W'($urandom);
   endfunction

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (gcnt < OMAX) got[gcnt] = out_data;
         if (out_first) begin first_cnt++; first_pos = gcnt; end
         if (out_last)  begin last_cnt++;  last_pos  = gcnt; done = 1'b1; end
         gcnt++;
      end
      if (tail && !(out_valid && out_last) && in_ready) ready_bad = 1'b1;
   end

   task automatic run_frame(input int n, input bit whole, input bit anti,
                            input bit gaps, input bit churn);
      bit frame_ok = 1'b1;
      gcnt = 0; first_cnt = 0; last_cnt = 0; first_pos = -1; last_pos = -1;
      done = 1'b0; ready_bad = 1'b0;
      // R11: unframed junk while idle
      in_valid = 1'b1; in_start = 1'b0; in_last = 1'b0; in_data = 16'h1357;
      repeat (2) @(negedge clk);
      in_valid = 1'b0;
      mode_whole = whole; mode_anti = anti;
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b0;
         if (gaps) repeat ($urandom % 3) @(negedge clk);
         while (!in_ready) @(negedge clk);
         in_valid = 1'b1; in_start = (i == 0); in_last = (i == n - 1); in_data = x[i];
         @(negedge clk);
         if (churn) begin mode_whole = 1'($urandom); mode_anti = 1'($urandom); end
      end
      in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
      chk(!in_ready, "R8 ready after last", in_ready, 0);
      tail = 1'b1;
      for (int t = 0; t < 400 && !done; t++) @(negedge clk);
      tail = 1'b0;
      chk(done, "R6 end marker seen", done, 1);
      chk(gcnt == n + 2 * E, "R6 frame length", gcnt, n + 2 * E);
      chk(first_cnt == 1 && first_pos == 0, "R6 first marker position", first_pos, 0);
      chk(last_cnt == 1 && last_pos == n + 2 * E - 1, "R6 last marker position", last_pos, n + 2 * E - 1);
      chk(!ready_bad, "R8 ready low during tail", ready_bad, 0);
      for (int k = 0; k < n + 2 * E && k < OMAX; k++) begin
         int p = k - E;
         int src;
         bit mir = 1'b1;
         string tag;
         logic signed [W-1:0] ev;
         if (p < 0) begin
            src = whole ? -p : -p - 1;
            tag = whole ? "R2 left whole" : "R1 left half";
         end else if (p >= n) begin
            src = whole ? 2 * (n - 1) - p : 2 * n - 1 - p;
            tag = "R3 right mirror";
         end else begin
            src = p; mir = 1'b0;
            tag = (n == E + 1) ? "R12 short interior" : "R9 interior";
         end
         ev = x[src];
         if (mir && anti) begin
            tag = (ev == VMIN) ? "R5 saturated negate" : "R4 negated padding";
            ev  = neg_sat(ev);
         end else if (!mir && anti) begin
            tag = "R4 interior kept";
         end
         if (k >= gcnt || got[k] != ev) frame_ok = 1'b0;
         chk(k < gcnt && got[k] == ev, tag, (k < gcnt) ? longint'(got[k]) : 0, longint'(ev));
      end
      if (churn) chk(frame_ok, "R7 modes held from start", frame_ok, 1);
      if (n == E + 1) chk(frame_ok, "R12 shortest frame", frame_ok, 1);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20231));
      tail = 1'b0;
      rst_n = 1'b0; in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
      in_data = '0; mode_whole = 1'b0; mode_anti = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
      chk(in_ready == 1'b1, "R10 in_ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed: ramp data, shortest and short frames, every mode
      for (int m = 0; m < 4; m++) begin
         for (int n = E + 1; n <= E + 3; n++) begin
            for (int i = 0; i < n; i++) x[i] = W'(100 * (i + 1));
            run_frame(n, m[0], m[1], 1'b0, 1'b0);
         end
      end

      // Directed: extreme values at the borders, anti-symmetric (R5)
      for (int m = 0; m < 2; m++) begin
         for (int i = 0; i < 12; i++) x[i] = (i % 2 == 0) ? VMIN : VMAX;
         run_frame(12, m[0], 1'b1, 1'b0, 1'b0);
         for (int i = 0; i < E + 1; i++) x[i] = VMIN;
         run_frame(E + 1, m[0], 1'b1, 1'b1, 1'b0);
      end

      // Random frames with gaps and mid-frame mode churn
      for (int f = 0; f < 48; f++) begin
         int n = E + 1 + int'($urandom % (NMAX - E));
         for (int i = 0; i < n; i++) x[i] = rand_val();
         run_frame(n, 1'($urandom), 1'($urandom), 1'($urandom), f[0]);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule